// File: doc/BRIEF.md
# Processor activity watchdog timer

This block watches a processor's activity strobe and pulls an active-low fault output low when the strobe stops changing level for too long. Software toggles the strobe as it runs. If the strobe sits at one level for the full timeout, the output falls. It is meant to drive the processor's non-maskable interrupt input.

The timer is held at zero while the supervisor reset is active. It is also held at zero while a flag says the strobe pin is undriven. A supply-low flag forces the output low on its own, whether or not the timer has run out. When the strobe pin is left open, the timer never runs, so the output works as a plain low-line indicator.

The strobe is a synchronized level, and a change is found by comparing it with its value one clock earlier. A rising change and a falling change both count as activity. The timeout is given as a count of clock cycles. The default is 80,000,000 cycles, which is 1.6 s at 50 MHz.

Top module: `activity_watchdog`

## Requirements
- R1: While `rst_n` is low, the timer stays at zero. `wdo_n_o` is high at every clock edge at which `supply_low_i` is low, whatever the strobe does.
- R2: While `strobe_float_i` is high, the timer stays at zero and never expires, however long the strobe stays still.
- R3: The timer counts only at edges where `rst_n` is high, `strobe_float_i` is low and the strobe has not changed. `wdo_n_o` falls at the TIMEOUT_CYCLES-th such edge in a row, and not at any earlier edge.
- R4: A strobe change of either direction, 0 to 1 or 1 to 0 (the sampled level differs from the level one clock earlier), restarts the timeout. A full new run of TIMEOUT_CYCLES idle edges is then needed before the output falls.
- R5: At any clock edge where `supply_low_i` is high, `wdo_n_o` goes low, whatever state the timer is in. When the flag clears, the output reflects the timer alone, and the timer's schedule is not disturbed.
- R6: While the strobe pin is undriven, `wdo_n_o` is low exactly at the edges where `supply_low_i` is high.
- R7: After a timeout, `wdo_n_o` stays low until one of three things happens: a strobe change, `rst_n` going low, or `strobe_float_i` going high. The first edge that sees any of these drives the output high, unless supply is low.
- R8: `wdo_n_o` is a register output. It changes only at a rising clock edge, and it reflects the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low supervisor reset; holds the timer at zero |
| strobe_i | input | 1 | Synchronized activity strobe level |
| strobe_float_i | input | 1 | High when the strobe pin is undriven |
| supply_low_i | input | 1 | High when the supply is below its threshold |
| wdo_n_o | output | 1 | Active-low watchdog / low-line output |

## Verification
Two pairs of events can fall on the same clock edge. The first pair is the supply-low flag and a timer expiry. The second pair is the supply-low flag and a strobe change that would otherwise release the output. The bench raises the supply flag exactly at the edge where the timeout is due, and separately at the edge that carries a strobe toggle. In both cases the output must be low at that edge. After the flag drops, the output must follow the timer state that a model without the supply flag predicts.

// File: rtl/activity_watchdog.sv
module activity_watchdog #(
  parameter int TIMEOUT_CYCLES = 80_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  input  logic strobe_float_i,
  input  logic supply_low_i,
  output logic wdo_n_o
);

  localparam int CNT_W = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  logic             strobe_q;
  logic [CNT_W-1:0] cnt, cnt_next;
  logic             expired, expired_next;
  logic             hold, activity;

  assign hold     = !rst_n || strobe_float_i;
  assign activity = strobe_i ^ strobe_q;

  always_comb begin
    cnt_next     = cnt;
    expired_next = expired;
    if (hold || activity) begin
      cnt_next     = '0;
      expired_next = 1'b0;
    end else if (cnt == LAST) begin
      expired_next = 1'b1;
    end else begin
      cnt_next = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    strobe_q <= strobe_i;
    cnt      <= cnt_next;
    expired  <= expired_next;
    wdo_n_o  <= !(supply_low_i || expired_next);
  end

  AST_RESET_HOLD: assert property (@(posedge clk)
    (!rst_n && !supply_low_i) |=> wdo_n_o);  // R1

  AST_FLOAT_LOWLINE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_float_i |=> (wdo_n_o == !$past(supply_low_i)));  // R6

  AST_TIMEOUT_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(wdo_n_o) && !$past(supply_low_i)) |-> ($past(cnt) == LAST));  // R3

  AST_ACTIVITY_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (activity && !supply_low_i) |=> wdo_n_o);  // R4

  AST_SUPPLY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low_i |=> !wdo_n_o);  // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);  // R3

endmodule

// File: tb/sim_activity_watchdog.sv
module sim_activity_watchdog;
  localparam int L = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0, strobe = 1'b0, flt = 1'b0, low = 1'b0;
  logic wdo_n;

  activity_watchdog #(.TIMEOUT_CYCLES(L)) u0 (
    .clk(clk), .rst_n(rst_n), .strobe_i(strobe), .strobe_float_i(flt),
    .supply_low_i(low), .wdo_n_o(wdo_n)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit    exp_q[$];
  string tag_q[$];
  bit    m_prev = 1'b0;
  int    m_idle = 0;

  task automatic drive(bit r, bit s, bit f, bit lo, string tag);
    bit act;
    @(negedge clk);
    rst_n = r; strobe = s; flt = f; low = lo;
    act = (s != m_prev);
    m_prev = s;
    if (!r || f || act) m_idle = 0;
    else m_idle++;
    exp_q.push_back(!(lo || m_idle >= L));
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) drive(1'b1, m_prev, 1'b0, 1'b0, tag);
  endtask

  always begin
    @(posedge clk);
    #2;
    if (exp_q.size() > 0) begin
      bit e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (wdo_n !== e) begin
        fails++;
        $display("FAIL %s: wdo_n_o=%b expected %b at %0t", t, wdo_n, e, $time);
      end
    end
  end

  task automatic finish_run();
    repeat (3) @(posedge clk);
    #5;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: run hung, actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset holds the timer, strobe toggles ignored
    for (int i = 0; i < 2 * L; i++) drive(1'b0, i[0], 1'b0, 1'b0, "R1");
    drive(1'b0, 1'b0, 1'b0, 1'b1, "R5");
    drive(1'b0, 1'b0, 1'b0, 1'b0, "R1");
    // R3: timeout lands exactly at the L-th idle edge
    idle(L - 1, "R3");
    idle(1, "R3");
    // R7: stays low while idle
    idle(5, "R7");
    // R4, R7: rising change releases
    drive(1'b1, 1'b1, 1'b0, 1'b0, "R4");
    idle(L, "R3");
    // R4: falling change releases
    drive(1'b1, 1'b0, 1'b0, 1'b0, "R4");
    idle(10, "R4");
    drive(1'b1, 1'b1, 1'b0, 1'b0, "R4");
    idle(L - 1, "R4");
    idle(1, "R3");
    // R7, R2: floating pin releases and holds
    drive(1'b1, 1'b1, 1'b1, 1'b0, "R7");
    for (int i = 0; i < 3 * L; i++) drive(1'b1, 1'b1, 1'b1, 1'b0, "R2");
    // R6: low-line behaviour while floating
    drive(1'b1, 1'b1, 1'b1, 1'b1, "R6");
    drive(1'b1, 1'b1, 1'b1, 1'b1, "R6");
    drive(1'b1, 1'b1, 1'b1, 1'b0, "R6");
    // reconnect and time out again, then reset releases
    idle(L, "R3");
    drive(1'b0, 1'b1, 1'b0, 1'b0, "R7");
    drive(1'b0, 1'b1, 1'b0, 1'b0, "R1");
    // R5: supply low mid-count, timer schedule unaffected
    idle(4, "R3");
    drive(1'b1, 1'b1, 1'b0, 1'b1, "R5");
    drive(1'b1, 1'b1, 1'b0, 1'b1, "R5");
    idle(L - 7, "R5");
    idle(1, "R5");
    // R5: supply low together with a strobe change
    drive(1'b1, 1'b0, 1'b0, 1'b1, "R5");
    drive(1'b1, 1'b0, 1'b0, 1'b0, "R4");
    // R5: supply low at the edge the timeout is due
    idle(L - 2, "R3");
    drive(1'b1, 1'b0, 1'b0, 1'b1, "R5");
    idle(2, "R7");
    // R8: output changes only at the clock edge
    @(negedge clk);
    low = 1'b1;
    #3;
    checks++;
    if (wdo_n !== 1'b0) begin
      fails++;
      $display("FAIL R8: wdo_n_o=%b expected 0 before edge", wdo_n);
    end
    low = 1'b0;
    drive(1'b1, 1'b1, 1'b0, 1'b0, "R8");
    drive(1'b1, 1'b1, 1'b0, 1'b1, "R8");
    #3;
    checks++;
    if (wdo_n !== 1'b1) begin
      fails++;
      $display("FAIL R8: wdo_n_o=%b expected 1 between negedge and edge", wdo_n);
    end
    drive(1'b1, 1'b1, 1'b0, 1'b0, "R8");
    finish_run();
  end
endmodule